// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block gives each of `NCORES` processor cores a private set of 32-bit registers for signalling interrupts between cores. A core reaches its own copy over a shared register bus, and the requester identifier on each access selects the copy. Each copy holds a pending-status word, an enable word, two write-only ports, a mailbox of 32-bit words and one interrupt line. One port sets status bits and the other clears them. The mailbox lets cores pass short messages alongside the interrupt.

A separate send register lets any core post an interrupt to another core. The write carries a target core number and a 5-bit vector. The vector becomes one status bit on the target, and the interrupt rules are the same as for a local set. A send that names a core that does not exist returns an error response and leaves all state alone.

The interrupt line keeps the asymmetry of the register model. A set can raise it whenever pending and enabled bits overlap. A clear can drop it only when status empties while enable is nonzero. In every other case the line keeps its previous value.

Top module: `ipi_bank`

## Requirements
- R1: After reset, every status, enable and mailbox word is zero, every `irq` bit is low, and every read returns zero.
- R2: Only `req_addr[7:0]` is decoded, and bits above it are ignored. The copy accessed is the one whose index equals `req_id`.
- R3: Offset 0x04 is the enable word, readable and writable. Writes to the status word at offset 0x00 have no effect, and reads of it return the current pending bits.
- R4: A write to offset 0x08 ORs the data into status. If status AND enable is then nonzero, `irq` for that core is driven high. Reads of offsets 0x08 and 0x0C return zero.
- R5: A write to offset 0x0C clears the status bits that are set in the data. `irq` goes low only if status is then zero and enable is nonzero; otherwise it keeps its value.
- R6: Offsets 0x20, 0x24, … 0x3C hold mailbox words 0 to 7 of the requesting core. Word index is (offset − 0x20)/4, and each word reads back what was last written to it.
- R7: A write to offset 0x40 takes the target core from data bits 25:16 and the vector from bits 4:0. It applies the R4 set rule to the target with data 1 << vector, whichever core issued it.
- R8: A send whose target is NCORES or higher sets `rsp_err` in its response and changes no state. No other access sets `rsp_err`.
- R9: Offsets 0x10–0x1C and 0x44–0xFF, and any offset not a multiple of 4, read as zero and are dropped on write.
- R10: Every accepted request gets exactly one response, with `rsp_valid` high on the next clock. A write response carries `rsp_rdata` equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; low 8 bits decoded |
| req_id | input | RID_W | Requesting core index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err | output | 1 | Send to a nonexistent core |
| irq | output | NCORES | Interrupt line per core |

## Verification
Directed sequences separate the set/clear asymmetry from a plain level-sensitive line. A clear that empties status while enable is zero must leave `irq` high, and a partial clear must not drop it. Sends to in-range and out-of-range targets, including the top vector 31 and stray data bits, show that only bits 25:16 and 4:0 are used. Aliased high address bits, unaligned offsets and holes in the map show that the decode ignores and drops exactly what it should. A long random mix of accesses across all cores is then checked against a behavioural model every cycle. The mix catches cross-core leaks, where one core's access changes another core's state.

// File: rtl/ipi_bank.sv
module ipi_bank #(
  parameter int NCORES     = 4,
  parameter int ADDR_W     = 16,
  parameter int MBOX_WORDS = 8,
  parameter int RID_W      = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [RID_W-1:0]  req_id,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NCORES-1:0] irq
);
  localparam logic [7:0] OFF_STAT = 8'h00;
  localparam logic [7:0] OFF_EN   = 8'h04;
  localparam logic [7:0] OFF_SET  = 8'h08;
  localparam logic [7:0] OFF_CLR  = 8'h0C;
  localparam logic [7:0] OFF_MB   = 8'h20;
  localparam logic [7:0] OFF_SEND = 8'h40;
  localparam logic [7:0] MB_END   = 8'(32 + 4 * MBOX_WORDS);
  localparam int         MB_IW    = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;
  localparam logic [9:0] NC10     = 10'(NCORES);

  logic [7:0]       off;
  logic             wr, rd, aligned;
  logic             hit_stat, hit_en, hit_set, hit_clr, hit_mb, hit_send;
  logic [MB_IW-1:0] mb_idx;
  logic [9:0]       tgt;
  logic             send_ok, send_go, send_bad;
  logic [31:0]      send_bit;
  logic [31:0]      rd_word [NCORES];
  logic [31:0]      rd_sel;

  assign off      = req_addr[7:0];
  assign wr       = req_valid && req_write;
  assign rd       = req_valid && !req_write;
  assign aligned  = (off[1:0] == 2'b00);
  assign hit_stat = aligned && (off == OFF_STAT);
  assign hit_en   = aligned && (off == OFF_EN);
  assign hit_set  = aligned && (off == OFF_SET);
  assign hit_clr  = aligned && (off == OFF_CLR);
  assign hit_send = aligned && (off == OFF_SEND);
  assign hit_mb   = aligned && (off >= OFF_MB) && (off < MB_END);
  assign mb_idx   = MB_IW'((off - OFF_MB) >> 2);

  assign tgt      = req_wdata[25:16];
  assign send_ok  = (tgt < NC10);
  assign send_go  = wr && hit_send && send_ok;
  assign send_bad = wr && hit_send && !send_ok;
  assign send_bit = 32'h1 << req_wdata[4:0];

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    logic [31:0] st_q, en_q, set_v, clr_v, st_n;
    logic [31:0] mb_q [MBOX_WORDS];
    logic        mine, remote, do_set, do_clr, irq_q;
    logic [31:0] core_rd;

    assign mine   = wr && (req_id == RID_W'(i));
    assign remote = send_go && (tgt == 10'(i));
    assign do_set = (mine && hit_set) || remote;
    assign do_clr = mine && hit_clr;
    assign set_v  = ((mine && hit_set) ? req_wdata : 32'h0) | (remote ? send_bit : 32'h0);
    assign clr_v  = do_clr ? req_wdata : 32'h0;
    assign st_n   = (st_q & ~clr_v) | set_v;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= '0;
        en_q  <= '0;
        irq_q <= 1'b0;
        for (int w = 0; w < MBOX_WORDS; w++) mb_q[w] <= '0;
      end else begin
        if (do_set || do_clr) st_q <= st_n;
        if (mine && hit_en) en_q <= req_wdata;
        if (mine && hit_mb) mb_q[mb_idx] <= req_wdata;
        if (do_set && ((st_n & en_q) != 32'h0))
          irq_q <= 1'b1;
        else if (do_clr && (st_n == 32'h0) && (en_q != 32'h0))
          irq_q <= 1'b0;
      end
    end

    always_comb begin
      core_rd = 32'h0;
      if (hit_stat)    core_rd = st_q;
      else if (hit_en) core_rd = en_q;
      else if (hit_mb) core_rd = mb_q[mb_idx];
    end

    assign rd_word[i] = core_rd;
    assign irq[i]     = irq_q;
  end

  always_comb begin
    rd_sel = 32'h0;
    for (int k = 0; k < NCORES; k++)
      if (req_id == RID_W'(k)) rd_sel = rd_word[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd ? rd_sel : 32'h0;
      rsp_err   <= send_bad;
    end
  end
endmodule

// File: rtl/ipi_bank_chk.sv
module ipi_bank_chk #(
  parameter int NCORES = 4,
  parameter int ADDR_W = 16,
  parameter int RID_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic [NCORES-1:0] irq
);
  logic [7:0] off;
  logic       bad_send, setlike, clrw;
  assign off      = req_addr[7:0];
  assign bad_send = req_valid && req_write && (off == 8'h40) && (req_wdata[25:16] >= 10'(NCORES));
  assign setlike  = req_valid && req_write && ((off == 8'h08) || (off == 8'h40));
  assign clrw     = req_valid && req_write && (off == 8'h0C);

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_write_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 32'h0));
  a_r4_setclr_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && ((off == 8'h08) || (off == 8'h0C))) |=> (rsp_rdata == 32'h0));
  a_r8_bad_send_errs: assert property (@(posedge clk) disable iff (!rst_n)
    bad_send |=> rsp_err);
  a_r8_err_only_bad_send: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(bad_send));

  for (genvar i = 0; i < NCORES; i++) begin : g_irq
    a_r4_irq_rise_on_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(setlike));
    a_r5_irq_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[i]) |-> $past(clrw));
  end
endmodule

bind ipi_bank ipi_bank_chk #(.NCORES(NCORES), .ADDR_W(ADDR_W), .RID_W(RID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
);

// File: tb/tb_ipi_bank.sv
`timescale 1ns/1ps
module tb_ipi_bank;
  localparam int N = 4;
  localparam int MB = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [1:0]  req_id;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [N-1:0] irq;

  ipi_bank #(.NCORES(N), .ADDR_W(16), .MBOX_WORDS(MB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_id(req_id), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_st [N];
  logic [31:0] m_en [N];
  logic [31:0] m_mb [N][MB];
  logic [N-1:0] m_irq;

  function automatic logic [31:0] m_read(int id, logic [15:0] a);
    logic [7:0] o = a[7:0];
    if (o[1:0] != 2'b00) return 32'h0;
    if (o == 8'h00) return m_st[id];
    if (o == 8'h04) return m_en[id];
    if (o >= 8'h20 && o <= 8'h3C) return m_mb[id][(o - 8'h20) / 4];
    return 32'h0;
  endfunction

  task automatic m_set(int id, logic [31:0] v);
    m_st[id] = m_st[id] | v;
    if ((m_st[id] & m_en[id]) != 0) m_irq[id] = 1'b1;
  endtask

  task automatic m_write(int id, logic [15:0] a, logic [31:0] d, output bit err);
    logic [7:0] o = a[7:0];
    int t;
    err = 0;
    if (o[1:0] != 2'b00) return;
    case (o)
      8'h04: m_en[id] = d;
      8'h08: m_set(id, d);
      8'h0C: begin
        m_st[id] = m_st[id] & ~d;
        if (m_st[id] == 0 && m_en[id] != 0) m_irq[id] = 1'b0;
      end
      8'h40: begin
        t = int'(d[25:16]);
        if (t >= N) err = 1;
        else m_set(t, 32'h1 << d[4:0]);
      end
      default: if (o >= 8'h20 && o <= 8'h3C) m_mb[id][(o - 8'h20) / 4] = d;
    endcase
  endtask

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic acc(bit w, int id, logic [15:0] a, logic [31:0] d, string req);
    logic [31:0] exp_rd;
    bit exp_err;
    req_valid = 1'b1; req_write = w; req_id = 2'(id); req_addr = a; req_wdata = d;
    exp_rd = w ? 32'h0 : m_read(id, a);
    exp_err = 0;
    if (w) m_write(id, a, d, exp_err);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check(rsp_valid === 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
    check(rsp_rdata === exp_rd, req, "rsp_rdata", 64'(rsp_rdata), 64'(exp_rd));
    check(rsp_err === exp_err, req, "rsp_err", 64'(rsp_err), 64'(exp_err));
    check(irq === m_irq, req, "irq", 64'(irq), 64'(m_irq));
  endtask

  task automatic rd_all(string req);
    for (int c = 0; c < N; c++) begin
      acc(0, c, 16'h0000, 0, req);
      acc(0, c, 16'h0004, 0, req);
      for (int w = 0; w < MB; w++) acc(0, c, 16'(8'h20 + 4 * w), 0, req);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && !req_valid)
      check(irq === m_irq, "R5", "irq idle", 64'(irq), 64'(m_irq));
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req_valid = 0; req_write = 0; req_addr = 0; req_id = 0; req_wdata = 0;
    m_irq = '0;
    for (int c = 0; c < N; c++) begin
      m_st[c] = 0; m_en[c] = 0;
      for (int w = 0; w < MB; w++) m_mb[c][w] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    check(irq === '0, "R1", "irq reset", 64'(irq), 64'd0);
    rd_all("R1");

    // R3 enable read/write, status write ignored
    acc(1, 1, 16'h0004, 32'h0000_00FF, "R3");
    acc(0, 1, 16'h0004, 0, "R3");
    acc(1, 1, 16'h0000, 32'h0000_FFFF, "R3");
    acc(0, 1, 16'h0000, 0, "R3");
    // R2 upper address bits ignored, per-core copy
    acc(0, 1, 16'hAB04, 0, "R2");
    acc(0, 0, 16'h0004, 0, "R2");
    // R4 set raises irq when enabled; set/clear read zero
    acc(1, 1, 16'h0008, 32'h0000_0003, "R4");
    acc(0, 1, 16'h0008, 0, "R4");
    acc(0, 1, 16'h000C, 0, "R4");
    acc(1, 2, 16'h0008, 32'h0000_0100, "R4");
    acc(0, 2, 16'h0000, 0, "R4");
    // R5 partial clear keeps irq; full clear drops it
    acc(1, 1, 16'h000C, 32'h0000_0001, "R5");
    acc(1, 1, 16'h000C, 32'h0000_0002, "R5");
    // R5 clear with enable zero leaves irq high
    acc(1, 0, 16'h0004, 32'h1, "R5");
    acc(1, 0, 16'h0008, 32'h1, "R5");
    acc(1, 0, 16'h0004, 32'h0, "R5");
    acc(1, 0, 16'h000C, 32'h1, "R5");
    acc(1, 0, 16'h0004, 32'h1, "R5");
    acc(1, 0, 16'h000C, 32'h0, "R5");
    // R6 mailbox words per core
    for (int w = 0; w < MB; w++) acc(1, 2, 16'(8'h20 + 4 * w), 32'hA500_0000 + 32'(w), "R6");
    acc(1, 3, 16'h0024, 32'hDEAD_BEEF, "R6");
    for (int w = 0; w < MB; w++) acc(0, 2, 16'(8'h20 + 4 * w), 0, "R6");
    acc(0, 3, 16'h0024, 0, "R6");
    // R7 sends
    acc(1, 3, 16'h0004, 32'h8000_0000, "R7");
    acc(1, 0, 16'h0040, 32'hFC03_FFFF, "R7");
    acc(0, 3, 16'h0000, 0, "R7");
    acc(1, 1, 16'h0040, 32'h0002_0005, "R7");
    acc(0, 2, 16'h0000, 0, "R7");
    // R8 bad targets
    acc(1, 0, 16'h0040, 32'h0004_0001, "R8");
    acc(1, 2, 16'h0040, 32'h03FF_0002, "R8");
    rd_all("R8");
    // R9 undefined offsets
    acc(1, 1, 16'h0010, 32'hFFFF_FFFF, "R9");
    acc(1, 1, 16'h0044, 32'hFFFF_FFFF, "R9");
    acc(1, 1, 16'h0022, 32'hFFFF_FFFF, "R9");
    acc(1, 1, 16'h0005, 32'hFFFF_FFFF, "R9");
    acc(0, 1, 16'h0010, 0, "R9");
    acc(0, 1, 16'h0044, 0, "R9");
    acc(0, 1, 16'h0021, 0, "R9");
    rd_all("R9");
    // R10 and cross-core random mix
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 11);
      logic [15:0] a;
      logic [31:0] d = $urandom;
      case (sel)
        0: a = 16'h0000;  1: a = 16'h0004;  2: a = 16'h0008;
        3: a = 16'h000C;  4: a = 16'h0040;  5: a = 16'h0048;
        default: a = 16'(8'h20 + 4 * $urandom_range(0, 7));
      endcase
      a[15:8] = 8'($urandom);
      if (sel == 4) d[25:16] = 10'($urandom_range(0, 5));
      if (sel == 3 && $urandom_range(0, 1) == 1) d = 32'hFFFF_FFFF;
      if (sel == 2) d = d & 32'h0000_00FF;
      acc($urandom_range(0, 1) == 1, $urandom_range(0, N - 1), a, d, "R10");
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    rd_all("R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule